// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This block is the control side of a multiplying PLL that supplies four frequency-synthesizer channels. It steps the PLL's control pins through a fixed order. An enable request releases the soft reset first. It then forces the reference-noise filter code to its nominal value, loads the feedback divider code, and finally powers the PLL up. After power-up it waits for the lock flag. If the flag does not arrive within a parameterised number of cycles, the enable ends with a timeout error. A disable request reverses the bring-up: power goes down first, and reset is reasserted on the following cycle.

Each optional feature can be left out by a compile-time parameter: reset control, filter control and lock status. When a feature is absent, its step still takes one cycle but writes nothing. The level that means "powered down" on the power pin is also a parameter. The block reports whether the PLL is powered, and it drives the resulting VCO multiplier, which is the divider code plus 16. The analog PLL sits outside the block.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset, `pll_rst_no` is 0 (1 when reset control is absent). `pdn_o` equals `PWR_POL`. `filt_o`, `ndiv_o`, `busy_o`, `locked_o`, `timeout_o` and `enabled_o` are all 0.
- R2: An enable is accepted at a clock edge, counted as cycle 1. Reset is released at cycle 2. The filter code 0 (nominal reference; 1, 2 and 3 are the degraded and improved reference codes) is written at cycle 3. The divider code appears at cycle 4. Power-up occurs at cycle 5.
- R3: `ndiv_i` is captured when the enable is accepted and later driven unchanged on `ndiv_o`. `ndiv_o` changes only while a sequence runs.
- R4: Power-up drives `pdn_o` to the inverse of `PWR_POL`, and power-down drives it to `PWR_POL`. `enabled_o` is 1 exactly when `pdn_o` differs from `PWR_POL`, and `locked_o` implies `enabled_o`.
- R5: With lock status present, the block stays busy after power-up until `lock_i` is sampled high. It then sets `locked_o` and leaves busy at that same edge. Lock seen on the last cycle of the window beats the timeout.
- R6: If lock is not seen within `TIMEOUT_CYC` edges after power-up, `timeout_o` is set, `busy_o` falls, `locked_o` stays 0 and the PLL stays powered. The next accepted enable clears `timeout_o`.
- R7: A disable is accepted at cycle 1. Power goes down at cycle 2, reset is reasserted and busy ends at cycle 3, and `locked_o` is cleared.
- R8: Enable and disable requests that arrive while `busy_o` is 1 are ignored. An enable that arrives while the PLL is locked is also ignored.
- R9: When reset control, filter control and lock status are all absent, `pll_rst_no` stays 1. The enable then completes with `locked_o` set at the power-up edge, which is cycle 5.
- R10: If enable and disable arrive together while idle or locked, the disable wins.
- R11: `vco_mult_o` equals `ndiv_o` + 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_req_i | input | 1 | Enable request strobe |
| dis_req_i | input | 1 | Disable request strobe |
| ndiv_i | input | NDIV_W | Feedback divider code to load |
| lock_i | input | 1 | PLL lock flag |
| pll_rst_no | output | 1 | PLL soft reset, active low |
| filt_o | output | 2 | Reference-noise filter code |
| ndiv_o | output | NDIV_W | Feedback divider code to PLL |
| pdn_o | output | 1 | Power control; equals PWR_POL when powered down |
| vco_mult_o | output | NDIV_W+2 | VCO multiplication factor |
| busy_o | output | 1 | A sequence is in progress |
| locked_o | output | 1 | Enable completed with lock |
| timeout_o | output | 1 | Last enable timed out waiting for lock |
| enabled_o | output | 1 | PLL is powered |

## Verification
The sequencer state is observed only through the control pins, so a state error shows up as a shifted cycle. A skipped or repeated step moves the rise of reset, the divider load or the power edge away from its fixed cycle. It becomes visible within one to five cycles of the request. A lock counter that starts late or wraps early moves the end of busy or flips the result between locked and timeout. The bench therefore sweeps every divider code against lock delays on both sides of the timeout boundary, and counts the completion cycle exactly.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REL_RST,
    ST_FILT,
    ST_NDIV,
    ST_PWR_UP,
    ST_WAIT,
    ST_ON,
    ST_PWR_DN,
    ST_ASRT_RST
  } seq_st_e;

  localparam int unsigned BW_W = 2;

  // reference-noise filter codes
  typedef enum logic [BW_W-1:0] {
    BW_GOOD  = 2'd0,
    BW_VBAD  = 2'd1,
    BW_BAD   = 2'd2,
    BW_VGOOD = 2'd3
  } bw_code_e;

endpackage

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter bit HAS_LOCK = 1'b1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_req_i,
  input  logic    dis_req_i,
  input  logic    lock_i,
  input  logic    tmo_i,
  output seq_st_e st_o,
  output logic    acc_en_o,
  output logic    acc_dis_o,
  output logic    lock_ok_o,
  output logic    tmo_hit_o,
  output logic    busy_o
);

  seq_st_e st_q, st_d;

  logic stable_st;
  assign stable_st = (st_q == ST_IDLE) || (st_q == ST_ON);

  // disable has priority; enable only from idle
  assign acc_dis_o = stable_st && dis_req_i;
  assign acc_en_o  = (st_q == ST_IDLE) && en_req_i && !dis_req_i;
  assign lock_ok_o = (st_q == ST_WAIT) && lock_i;
  assign tmo_hit_o = (st_q == ST_WAIT) && !lock_i && tmo_i;
  assign busy_o    = !stable_st;
  assign st_o      = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (acc_dis_o)     st_d = ST_PWR_DN;
        else if (acc_en_o) st_d = ST_REL_RST;
      end
      ST_ON:       if (acc_dis_o) st_d = ST_PWR_DN;
      ST_REL_RST:  st_d = ST_FILT;
      ST_FILT:     st_d = ST_NDIV;
      ST_NDIV:     st_d = ST_PWR_UP;
      ST_PWR_UP:   st_d = HAS_LOCK ? ST_WAIT : ST_ON;
      ST_WAIT: begin
        if (lock_ok_o)      st_d = ST_ON;
        else if (tmo_hit_o) st_d = ST_IDLE;
      end
      ST_PWR_DN:   st_d = ST_ASRT_RST;
      ST_ASRT_RST: st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int unsigned LIMIT = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);

  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
  import pll_seq_pkg::*;
#(
  parameter bit          HAS_RESET  = 1'b1,
  parameter bit          HAS_FILTER = 1'b1,
  parameter bit          HAS_LOCK   = 1'b1,
  parameter bit          PWR_POL    = 1'b1,
  parameter int unsigned NDIV_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_st_e           st_i,
  input  logic              acc_en_i,
  input  logic              acc_dis_i,
  input  logic              lock_ok_i,
  input  logic              tmo_hit_i,
  input  logic [NDIV_W-1:0] ndiv_i,
  output logic              pll_rst_no,
  output logic [BW_W-1:0]   filt_o,
  output logic [NDIV_W-1:0] ndiv_o,
  output logic              pdn_o,
  output logic              locked_o,
  output logic              timeout_o
);

  logic [NDIV_W-1:0] ndiv_cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ndiv_cap_q <= '0;
    else if (acc_en_i) ndiv_cap_q <= ndiv_i;
  end

  generate
    if (HAS_RESET) begin : g_rst
      logic rst_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   rst_q <= 1'b0;
        else if (st_i == ST_REL_RST)   rst_q <= 1'b1;
        else if (st_i == ST_ASRT_RST)  rst_q <= 1'b0;
      end
      assign pll_rst_no = rst_q;
    end else begin : g_no_rst
      assign pll_rst_no = 1'b1;
    end

    if (HAS_FILTER) begin : g_filt
      logic [BW_W-1:0] filt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              filt_q <= '0;
        else if (st_i == ST_FILT) filt_q <= BW_GOOD;
      end
      assign filt_o = filt_q;
    end else begin : g_no_filt
      assign filt_o = BW_GOOD;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ndiv_o <= '0;
      pdn_o  <= PWR_POL;
    end else begin
      if (st_i == ST_NDIV)   ndiv_o <= ndiv_cap_q;
      if (st_i == ST_PWR_UP) pdn_o  <= ~PWR_POL;
      if (st_i == ST_PWR_DN) pdn_o  <= PWR_POL;
    end
  end

  logic done_set;
  assign done_set = lock_ok_i || (!HAS_LOCK && (st_i == ST_PWR_UP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o  <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      if (acc_en_i || acc_dis_i) locked_o <= 1'b0;
      else if (done_set)         locked_o <= 1'b1;
      if (acc_en_i || acc_dis_i) timeout_o <= 1'b0;
      else if (tmo_hit_i)        timeout_o <= 1'b1;
    end
  end

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_seq_pkg::*;
#(
  parameter bit          HAS_RESET   = 1'b1,
  parameter bit          HAS_FILTER  = 1'b1,
  parameter bit          HAS_LOCK    = 1'b1,
  parameter bit          PWR_POL     = 1'b1,
  parameter int unsigned NDIV_W      = 3,
  parameter int unsigned MULT_OFS    = 16,
  parameter int unsigned TIMEOUT_CYC = 2_000_000,
  localparam int unsigned MULT_W     = NDIV_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_req_i,
  input  logic              dis_req_i,
  input  logic [NDIV_W-1:0] ndiv_i,
  input  logic              lock_i,
  output logic              pll_rst_no,
  output logic [1:0]        filt_o,
  output logic [NDIV_W-1:0] ndiv_o,
  output logic              pdn_o,
  output logic [MULT_W-1:0] vco_mult_o,
  output logic              busy_o,
  output logic              locked_o,
  output logic              timeout_o,
  output logic              enabled_o
);

  seq_st_e st;
  logic acc_en, acc_dis, lock_ok, tmo_hit, tmo;

  pll_seq_fsm #(.HAS_LOCK(HAS_LOCK)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_req_i (en_req_i),
    .dis_req_i(dis_req_i),
    .lock_i   (lock_i),
    .tmo_i    (tmo),
    .st_o     (st),
    .acc_en_o (acc_en),
    .acc_dis_o(acc_dis),
    .lock_ok_o(lock_ok),
    .tmo_hit_o(tmo_hit),
    .busy_o   (busy_o)
  );

  generate
    if (HAS_LOCK) begin : g_tmr
      pll_lock_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (st == ST_WAIT),
        .expire_o(tmo)
      );
    end else begin : g_no_tmr
      assign tmo = 1'b0;
    end
  endgenerate

  pll_ctrl_regs #(
    .HAS_RESET (HAS_RESET),
    .HAS_FILTER(HAS_FILTER),
    .HAS_LOCK  (HAS_LOCK),
    .PWR_POL   (PWR_POL),
    .NDIV_W    (NDIV_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_i      (st),
    .acc_en_i  (acc_en),
    .acc_dis_i (acc_dis),
    .lock_ok_i (lock_ok),
    .tmo_hit_i (tmo_hit),
    .ndiv_i    (ndiv_i),
    .pll_rst_no(pll_rst_no),
    .filt_o    (filt_o),
    .ndiv_o    (ndiv_o),
    .pdn_o     (pdn_o),
    .locked_o  (locked_o),
    .timeout_o (timeout_o)
  );

  assign vco_mult_o = MULT_W'(ndiv_o) + MULT_W'(MULT_OFS);
  assign enabled_o  = (pdn_o != PWR_POL);

endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk #(
  parameter bit          PWR_POL = 1'b1,
  parameter int unsigned NDIV_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pll_rst_no,
  input logic              pdn_o,
  input logic [NDIV_W-1:0] ndiv_o,
  input logic              busy_o,
  input logic              locked_o,
  input logic              timeout_o,
  input logic              enabled_o
);

  // R2: power is never up while reset is held
  p_rst_before_pwr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_o != PWR_POL) |-> pll_rst_no);

  // R7: reset only reasserted after power-down
  p_pwr_before_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_rst_no) |-> (pdn_o == PWR_POL));

  // R4
  p_locked_pwr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> enabled_o);

  // R3
  p_ndiv_in_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ndiv_o) |-> $past(busy_o));

  // R6
  p_tmo_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!locked_o && !busy_o && enabled_o));

  // R8: power-up only inside an accepted sequence
  p_pwrup_seq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enabled_o) |-> $past(busy_o));

endmodule

bind pll_pwr_seq pll_pwr_seq_chk #(.PWR_POL(PWR_POL), .NDIV_W(NDIV_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pll_rst_no(pll_rst_no),
  .pdn_o     (pdn_o),
  .ndiv_o    (ndiv_o),
  .busy_o    (busy_o),
  .locked_o  (locked_o),
  .timeout_o (timeout_o),
  .enabled_o (enabled_o)
);

// File: tb/pll_pwr_seq_test.sv
`timescale 1ns/1ps
module pll_pwr_seq_test;

  localparam int T = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // main instance: all features, PWR_POL=1
  logic       en_a = 0, dis_a = 0, lock_a;
  logic [2:0] code_a = 0;
  logic       rstn_a, pdn_a, busy_a, lkd_a, tmo_a, ena_a;
  logic [1:0] filt_a;
  logic [2:0] ndiv_a;
  logic [4:0] mult_a;

  pll_pwr_seq #(.TIMEOUT_CYC(T)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en_a), .dis_req_i(dis_a),
    .ndiv_i(code_a), .lock_i(lock_a), .pll_rst_no(rstn_a), .filt_o(filt_a),
    .ndiv_o(ndiv_a), .pdn_o(pdn_a), .vco_mult_o(mult_a), .busy_o(busy_a),
    .locked_o(lkd_a), .timeout_o(tmo_a), .enabled_o(ena_a)
  );

  // reduced instance: no reset, filter or lock, PWR_POL=0
  logic       en_b = 0, dis_b = 0;
  logic [2:0] code_b = 0;
  logic       rstn_b, pdn_b, busy_b, lkd_b, tmo_b, ena_b;
  logic [1:0] filt_b;
  logic [2:0] ndiv_b;
  logic [4:0] mult_b;

  pll_pwr_seq #(.HAS_RESET(1'b0), .HAS_FILTER(1'b0), .HAS_LOCK(1'b0),
                .PWR_POL(1'b0), .TIMEOUT_CYC(T)) uut_min (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en_b), .dis_req_i(dis_b),
    .ndiv_i(code_b), .lock_i(1'b0), .pll_rst_no(rstn_b), .filt_o(filt_b),
    .ndiv_o(ndiv_b), .pdn_o(pdn_b), .vco_mult_o(mult_b), .busy_o(busy_b),
    .locked_o(lkd_b), .timeout_o(tmo_b), .enabled_o(ena_b)
  );

  // analog PLL model: lock after lock_dly cycles of power
  int lock_dly = 0;
  int up_cnt = 0;
  always @(posedge clk) up_cnt <= (pdn_a == 1'b0) ? up_cnt + 1 : 0;
  assign lock_a = (pdn_a == 1'b0) && (up_cnt >= lock_dly);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // pulse request on uut, count cycles until idle, note first change of pins
  task automatic req_a(input bit e, input bit d, output int n,
                       output int c_rst, output int c_nd, output int c_pdn);
    logic r0, p0;
    logic [2:0] nd0;
    r0 = rstn_a; p0 = pdn_a; nd0 = ndiv_a;
    c_rst = 0; c_nd = 0; c_pdn = 0;
    @(negedge clk); en_a = e; dis_a = d;
    @(posedge clk); #1; en_a = 0; dis_a = 0; n = 1;
    forever begin
      if (c_rst == 0 && rstn_a != r0) c_rst = n;
      if (c_nd == 0 && ndiv_a != nd0) c_nd = n;
      if (c_pdn == 0 && pdn_a != p0) c_pdn = n;
      if (!busy_a || n >= 200) break;
      @(posedge clk); #1; n++;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n, cr, cn, cp;
    int dl[6];
    logic [2:0] prev;
    dl = '{0, 3, T-2, T-1, T, T+3};
    #12; rst_n = 1; #1;
    // R1
    chk("R1 rst_n", rstn_a, 0);   chk("R1 pdn", pdn_a, 1);
    chk("R1 filt", filt_a, 0);    chk("R1 ndiv", ndiv_a, 0);
    chk("R1 busy", busy_a, 0);    chk("R1 locked", lkd_a, 0);
    chk("R1 tmo", tmo_a, 0);      chk("R1 enabled", ena_a, 0);
    chk("R1 min rst_n", rstn_b, 1); chk("R1 min pdn", pdn_b, 0);

    prev = 0;
    foreach (dl[i]) begin
      for (int k = 0; k < 8; k++) begin
        lock_dly = dl[i];
        code_a = 3'(k);
        req_a(1, 0, n, cr, cn, cp);
        chk("R2 rst release cycle", cr, 2);
        chk("R2 power-up cycle", cp, 5);
        if (3'(k) != prev) chk("R2 ndiv load cycle", cn, 4);
        chk("R2 filt code", filt_a, 0);
        chk("R3 ndiv value", ndiv_a, k);
        chk("R11 mult", mult_a, k + 16);
        chk("R4 pdn up level", pdn_a, 0);
        chk("R4 enabled", ena_a, 1);
        if (dl[i] < T) begin
          chk("R5 lock completion cycle", n, 6 + dl[i]);
          chk("R5 locked", lkd_a, 1);
          chk("R6 tmo clear", tmo_a, 0);
        end else begin
          chk("R6 timeout cycle", n, 5 + T);
          chk("R6 timeout flag", tmo_a, 1);
          chk("R6 not locked", lkd_a, 0);
        end
        prev = 3'(k);
        req_a(0, 1, n, cr, cn, cp);
        chk("R7 disable cycles", n, 3);
        chk("R7 power-down cycle", cp, 2);
        chk("R7 reset cycle", cr, 3);
        chk("R7 locked cleared", lkd_a, 0);
        chk("R4 pdn down level", pdn_a, 1);
        chk("R6 tmo cleared", tmo_a, 0);
      end
    end

    // R8: requests during lock wait are ignored
    lock_dly = 8; code_a = 3'd5;
    @(negedge clk); en_a = 1;
    @(posedge clk); #1; en_a = 0;
    repeat (5) @(posedge clk);
    @(negedge clk); code_a = 3'd2; en_a = 1; dis_a = 1;
    @(posedge clk); #1; en_a = 0; dis_a = 0;
    n = 7;
    while (busy_a && n < 200) begin @(posedge clk); #1; n++; end
    chk("R8 busy request cycle", n, 6 + 8);
    chk("R8 ndiv kept", ndiv_a, 5);
    chk("R8 still locked", lkd_a, 1);
    chk("R8 still enabled", ena_a, 1);
    // R8: enable while locked ignored
    code_a = 3'd1;
    req_a(1, 0, n, cr, cn, cp);
    repeat (5) @(posedge clk); #1;
    chk("R8 on-state enable busy", busy_a, 0);
    chk("R8 on-state ndiv", ndiv_a, 5);
    chk("R8 on-state locked", lkd_a, 1);
    // R10: both in on state -> disable
    req_a(1, 1, n, cr, cn, cp);
    chk("R10 on both cycles", n, 3);
    chk("R10 on both powered down", ena_a, 0);
    chk("R10 on both rst", rstn_a, 0);
    // R10: both in idle -> disable
    code_a = 3'd3;
    req_a(1, 1, n, cr, cn, cp);
    chk("R10 idle both cycles", n, 3);
    chk("R10 idle both ndiv", ndiv_a, 5);
    chk("R10 idle both enabled", ena_a, 0);

    // R9: reduced configuration
    code_b = 3'd6;
    @(negedge clk); en_b = 1;
    @(posedge clk); #1; en_b = 0; n = 1;
    while (busy_b && n < 200) begin @(posedge clk); #1; n++; end
    chk("R9 min enable cycles", n, 5);
    chk("R9 min locked", lkd_b, 1);
    chk("R9 min rst_n", rstn_b, 1);
    chk("R4 min pdn up", pdn_b, 1);
    chk("R11 min mult", mult_b, 22);
    @(negedge clk); dis_b = 1;
    @(posedge clk); #1; dis_b = 0; n = 1;
    while (busy_b && n < 200) begin @(posedge clk); #1; n++; end
    chk("R9 min disable cycles", n, 3);
    chk("R4 min pdn down", pdn_b, 0);
    chk("R9 min rst_n after", rstn_b, 1);
    chk("R9 min locked clear", lkd_b, 0);

    finish_run();
  end

endmodule